// File: doc/BRIEF.md
# Truncated Multiply-Add Expression Unit

This block evaluates the expression A + B·C on three 8-bit unsigned operands and returns the low 8 bits of the result. Multiplication binds tighter than addition. The product is formed first by a shift-and-add array of gated partial-product rows, and every accumulation stage keeps only its low 8 bits. The truncated product then enters a ripple-carry adder together with A. That adder's carry-out is also dropped, so the whole expression wraps modulo 256.

Operands and results cross the ports most-significant bit first: vector index 0 holds the value's top bit. The internal arithmetic works in ordinary positional order, and the reversal happens at the edge of the block.

The combinational result is always visible. An optional output register captures it on an input strobe and raises a one-cycle valid flag, so the result can also be observed cycle by cycle.

Top module: `trunc_muladd`

## Requirements
- R1: `sum_comb_msbf` always equals (A + B·C) mod 256 for the operands currently on the ports, with no clock involved.
- R2: Multiplication is applied before addition. For example, 5 + 3·2 gives 11, not 16.
- R3: The final addition wraps and discards its carry. 1 + 15·17 gives 0, and 255 + 255·255 gives 0.
- R4: The product is reduced modulo 256 before A is added. 0 + 16·16 gives 0, and 3 + 20·20 gives 147.
- R5: All operand and result vectors are MSB-first: index 0 carries value bit 7 and index 7 carries value bit 0. For example, `a_msbf` = 8'b0000_0001 means A = 128, and a result of 128 appears as 8'b0000_0001.
- R6: The corner cases hold: 0 + 0·0 = 0, 255 + 0·0 = 255, 0 + 255·1 = 255, and 0 + 1·255 = 255.
- R7: With the register enabled, a high `in_valid` at a rising edge loads the result into `sum_msbf` and sets `out_valid` for the following cycle only.
- R8: While `in_valid` is low, `sum_msbf` holds its value even if the operands change, and `out_valid` stays low.
- R9: A synchronous active-high `rst` clears `sum_msbf` to 0 and `out_valid` to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that loads the current result |
| a_msbf | input | WIDTH | Addend A, MSB-first |
| b_msbf | input | WIDTH | Multiplicand B, MSB-first |
| c_msbf | input | WIDTH | Multiplier C, MSB-first |
| sum_comb_msbf | output | WIDTH | Combinational (A + B·C) mod 2^WIDTH, MSB-first |
| sum_msbf | output | WIDTH | Registered result, MSB-first |
| out_valid | output | 1 | One-cycle flag marking a freshly loaded `sum_msbf` |

## Verification
The bench builds the block with WIDTH = 8 and REG_OUT = 1. This puts both the combinational path and the strobe-capture register under test in the same run. At eight bits, every wrap case can be reached with hand-picked operands, including a product that overflows before A is added and a sum that overflows afterwards. Raw MSB-first patterns are driven directly to pin down the bit order, and a small sweep plus random vectors are checked against an arithmetic model.

// File: rtl/trunc_muladd.sv
module trunc_muladd #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] a_msbf,
  input  logic [WIDTH-1:0] b_msbf,
  input  logic [WIDTH-1:0] c_msbf,
  output logic [WIDTH-1:0] sum_comb_msbf,
  output logic [WIDTH-1:0] sum_msbf,
  output logic             out_valid
);

  localparam int STAGES = WIDTH;
  localparam int TOP    = WIDTH - 1;

  logic [WIDTH-1:0] a_pos, b_pos, c_pos;
  logic [WIDTH-1:0] row [STAGES];
  logic [WIDTH-1:0] acc [STAGES];
  logic [WIDTH-1:0] total;

  // edge reversal: MSB-first ports to positional order
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign a_pos[i] = a_msbf[TOP-i];
    assign b_pos[i] = b_msbf[TOP-i];
    assign c_pos[i] = c_msbf[TOP-i];
    assign sum_comb_msbf[i] = total[TOP-i];
  end

  // gated partial-product rows
  for (genvar s = 0; s < STAGES; s++) begin : g_row
    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
      assign row[s][k] = b_pos[k] & c_pos[s];
    end
  end

  assign acc[0] = row[0];

  // accumulation stages, each a truncated ripple chain
  for (genvar s = 1; s < STAGES; s++) begin : g_acc
    logic [WIDTH-1:0] addend;
    logic [WIDTH-1:0] cin;
    assign cin[0] = 1'b0;
    for (genvar k = 0; k < WIDTH; k++) begin : g_fa
      logic h1_s, h1_c, h2_c;
      if (k < s) begin : g_zero
        assign addend[k] = 1'b0;
      end else begin : g_shift
        assign addend[k] = row[s][k-s];
      end
      assign h1_s      = acc[s-1][k] ^ addend[k];
      assign h1_c      = acc[s-1][k] & addend[k];
      assign acc[s][k] = h1_s ^ cin[k];
      assign h2_c      = h1_s & cin[k];
      if (k < TOP) begin : g_carry
        assign cin[k+1] = h1_c | h2_c;
      end else begin : g_drop
        logic unused_carry;
        assign unused_carry = h1_c | h2_c;
      end
    end
  end

  // final adder: A plus truncated product
  logic [WIDTH-1:0] fcin;
  assign fcin[0] = 1'b0;
  for (genvar k = 0; k < WIDTH; k++) begin : g_fin
    logic h1_s, h1_c, h2_c;
    assign h1_s     = a_pos[k] ^ acc[STAGES-1][k];
    assign h1_c     = a_pos[k] & acc[STAGES-1][k];
    assign total[k] = h1_s ^ fcin[k];
    assign h2_c     = h1_s & fcin[k];
    if (k < TOP) begin : g_carry
      assign fcin[k+1] = h1_c | h2_c;
    end else begin : g_drop
      logic unused_carry;
      assign unused_carry = h1_c | h2_c;
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sum_msbf  <= '0;
        out_valid <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) sum_msbf <= sum_comb_msbf;
      end
    end
  end else begin : g_pass
    assign sum_msbf  = sum_comb_msbf;
    assign out_valid = in_valid;
  end

endmodule

module trunc_muladd_chk #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [WIDTH-1:0] a_msbf,
  input logic [WIDTH-1:0] b_msbf,
  input logic [WIDTH-1:0] c_msbf,
  input logic [WIDTH-1:0] sum_comb_msbf,
  input logic [WIDTH-1:0] sum_msbf,
  input logic             out_valid
);

  function automatic logic [WIDTH-1:0] flip(input logic [WIDTH-1:0] v);
    for (int i = 0; i < WIDTH; i++) flip[i] = v[WIDTH-1-i];
  endfunction

  function automatic logic [WIDTH-1:0] model(input logic [WIDTH-1:0] a,
                                             input logic [WIDTH-1:0] b,
                                             input logic [WIDTH-1:0] c);
    logic [2*WIDTH-1:0] wide;
    wide = {{WIDTH{1'b0}}, flip(a)} + {{WIDTH{1'b0}}, flip(b)} * {{WIDTH{1'b0}}, flip(c)};
    return flip(wide[WIDTH-1:0]);
  endfunction

  // R1 R2 R3 R4 R5: combinational value matches the arithmetic model
  a_r1_comb_value: assert property (@(posedge clk) disable iff (rst)
    sum_comb_msbf == model(a_msbf, b_msbf, c_msbf));

  if (REG_OUT) begin : g_reg_chk
    a_r7_capture: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_valid && sum_msbf == $past(model(a_msbf, b_msbf, c_msbf))));
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(sum_msbf));
    a_r9_reset: assert property (@(posedge clk)
      rst |=> (!out_valid && sum_msbf == '0));
  end

endmodule

bind trunc_muladd trunc_muladd_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) chk_i (.*);

// File: tb/trunc_muladd_tb.sv
module trunc_muladd_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  // {A, B, C, expected}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd5,   8'd3,   8'd2,   8'd11},
    {8'd10,  8'd4,   8'd3,   8'd22},
    {8'd1,   8'd10,  8'd10,  8'd101},
    {8'd100, 8'd5,   8'd5,   8'd125},
    {8'd0,   8'd15,  8'd17,  8'd255},
    {8'd1,   8'd15,  8'd17,  8'd0},
    {8'd0,   8'd16,  8'd16,  8'd0},
    {8'd3,   8'd20,  8'd20,  8'd147},
    {8'd200, 8'd100, 8'd3,   8'd244},
    {8'd255, 8'd255, 8'd255, 8'd0},
    {8'd0,   8'd0,   8'd0,   8'd0},
    {8'd255, 8'd0,   8'd0,   8'd255},
    {8'd0,   8'd255, 8'd1,   8'd255},
    {8'd0,   8'd1,   8'd255, 8'd255}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] a_msbf = '0, b_msbf = '0, c_msbf = '0;
  logic [7:0] sum_comb_msbf, sum_msbf;
  logic out_valid;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trunc_muladd #(.WIDTH(8), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_msbf(a_msbf), .b_msbf(b_msbf), .c_msbf(c_msbf),
    .sum_comb_msbf(sum_comb_msbf), .sum_msbf(sum_msbf), .out_valid(out_valid)
  );

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  function automatic logic [7:0] ref_val(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] c);
    logic [15:0] w;
    w = 16'(a) + 16'(b) * 16'(c);
    return w[7:0];
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive values at negedge, check comb, then check register after one edge
  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                       input logic [7:0] exp, input string tag);
    a_msbf = rev8(a); b_msbf = rev8(b); c_msbf = rev8(c);
    in_valid = 1'b1;
    #1;
    chk(rev8(sum_comb_msbf), exp, {tag, " comb"});
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(rev8(sum_msbf), exp, {tag, " R7 reg"});
    chk({7'd0, out_valid}, 8'd1, {tag, " R7 valid"});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R9: reset state
    chk(sum_msbf, 8'd0, "R9 reset sum");
    chk({7'd0, out_valid}, 8'd0, "R9 reset valid");
    rst = 1'b0;
    @(negedge clk);

    // table: R1 R2 R3 R4 R6
    for (int i = 0; i < NVEC; i++)
      apply(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], "R1 table");

    // R2: precedence, not left-to-right
    apply(8'd5, 8'd3, 8'd2, 8'd11, "R2 precedence");
    // R3 R4: product truncated then wrap
    apply(8'd1, 8'd15, 8'd17, 8'd0, "R3 wrap");
    apply(8'd0, 8'd16, 8'd16, 8'd0, "R4 product trunc");
    // R6 corners
    apply(8'd0, 8'd255, 8'd1, 8'd255, "R6 corner");

    // R5: raw MSB-first patterns
    a_msbf = 8'b0000_0001; b_msbf = 8'd0; c_msbf = 8'd0;
    #1 chk(sum_comb_msbf, 8'b0000_0001, "R5 A=128 raw");
    a_msbf = 8'd0; b_msbf = 8'b0000_0001; c_msbf = 8'b1000_0000;
    #1 chk(sum_comb_msbf, 8'b0000_0001, "R5 B=128 C=1 raw");
    a_msbf = 8'b1000_0000; b_msbf = 8'd0; c_msbf = 8'd0;
    #1 chk(sum_comb_msbf, 8'b1000_0000, "R5 A=1 raw");
    @(negedge clk);

    // sweep
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        for (int c = 0; c < 4; c++) begin
          logic [7:0] av;
          av = (a == 0) ? 8'd0 : (a == 1) ? 8'd1 : (a == 2) ? 8'd5 : 8'd10;
          apply(av, 8'(b), 8'(c), ref_val(av, 8'(b), 8'(c)), "R1 sweep");
        end
      end
    end

    // random
    for (int n = 0; n < 200; n++) begin
      logic [7:0] ra, rb, rc;
      ra = 8'($urandom); rb = 8'($urandom); rc = 8'($urandom);
      apply(ra, rb, rc, ref_val(ra, rb, rc), "R1 random");
    end

    // R8: hold while in_valid low
    apply(8'd10, 8'd4, 8'd3, 8'd22, "R8 setup");
    a_msbf = rev8(8'd77); b_msbf = rev8(8'd9); c_msbf = rev8(8'd9);
    @(posedge clk); @(negedge clk);
    chk(rev8(sum_msbf), 8'd22, "R8 hold sum");
    chk({7'd0, out_valid}, 8'd0, "R8 valid low");
    chk(rev8(sum_comb_msbf), 8'd158, "R1 comb while idle");

    // R9: reset after a capture
    apply(8'd100, 8'd5, 8'd5, 8'd125, "R9 setup");
    in_valid = 1'b1;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(sum_msbf, 8'd0, "R9 sync reset sum");
    chk({7'd0, out_valid}, 8'd0, "R9 sync reset valid");
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule